// File: doc/BRIEF.md
# Floating-point compare flag generator

This block orders two IEEE-754 binary operands (binary32 at the default widths), called the left operand and the right operand. It reports the result as a four-bit condition vector `{N, Z, C, V}` together with an invalid-operation bit. The comparison works directly on the packed sign-magnitude bit patterns, so no field unpacking and no subtractor are needed. A compare-against-zero input replaces the right operand with +0. A signalling-mode input makes quiet NaNs raise invalid as well as signalling ones.

The logic is combinational. A parameter places a register on the outputs, which is the default. With the register, the result of the inputs present at a rising clock edge appears after that edge. The block only produces flags. Storing them into a status register is left to the surrounding pipeline.

Top module: `fcmp_flags`

## Requirements
- R1: An operand whose exponent field is all ones and whose mantissa is nonzero is a NaN. If either operand is a NaN, the result is unordered: `nzcv` = 4'b0011. The bit order is N = bit 3, Z = bit 2, C = bit 1, V = bit 0.
- R2: `inv` is 1 when a NaN operand has its mantissa MSB clear (bit 22 at the default widths), or when `sig_quiet` is 1 and any operand is a NaN. In every other case `inv` is 0.
- R3: Without NaNs, the operands are equal when their bit patterns are identical, or when both are zeros of either sign. Equal gives `nzcv` = 4'b0110.
- R4: Without NaNs, and when the operands are not equal, an operand with sign bit 1 is less than an operand with sign bit 0.
- R5: Without NaNs and with equal signs, the order follows the magnitude, with infinity above every finite value. For two negative operands the order is inverted.
- R6: Left less than right gives `nzcv` = 4'b1000. Left greater than right gives 4'b0010. No other codes are produced besides 0011, 0110, 1000 and 0010.
- R7: When `cmp_zero` is 1, the right operand is taken as +0 and `b_op` has no effect on either output.
- R8: With `REG_OUT` = 1, the outputs are 0 during reset. After reset they show the result of the inputs sampled at the previous rising edge, and they hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_op | input | 1+EXP_W+MAN_W | Left operand, packed |
| b_op | input | 1+EXP_W+MAN_W | Right operand, packed |
| sig_quiet | input | 1 | Quiet NaNs also raise invalid |
| cmp_zero | input | 1 | Use +0 in place of `b_op` |
| nzcv | output | 4 | Condition flags {N,Z,C,V} |
| inv | output | 1 | Invalid-operation flag |

## Verification
Three cases are easy to miss when only a few hand-picked values are driven:
- a signalling NaN paired with a quiet NaN, in either operand position and under both modes;
- a negative zero compared against a positive zero;
- two negative values whose magnitude order must be flipped.

The bench therefore uses a reduced format with a 3-bit exponent and a 2-bit mantissa. It sweeps every operand pair under every setting of the two mode inputs, so every NaN payload, both zeros and both infinities meet each other. Expected orderings come from converting each pattern to a signed integer value scaled by its exponent.

// File: rtl/fcmp_flags.sv
module fcmp_flags #(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [EXP_W+MAN_W:0]   a_op,
  input  logic [EXP_W+MAN_W:0]   b_op,
  input  logic                   sig_quiet,
  input  logic                   cmp_zero,
  output logic [3:0]             nzcv,
  output logic                   inv
);
  localparam int MSB = EXP_W + MAN_W;

  logic [MSB:0] m_op;
  logic         nan_a, nan_m, unord, inv_c;
  logic         same, lt;
  logic [3:0]   flags_c;

  assign m_op  = cmp_zero ? '0 : b_op;
  assign nan_a = (&a_op[MSB-1:MAN_W]) && (|a_op[MAN_W-1:0]);
  assign nan_m = (&m_op[MSB-1:MAN_W]) && (|m_op[MAN_W-1:0]);
  assign unord = nan_a || nan_m;
  assign inv_c = (nan_a && (!a_op[MAN_W-1] || sig_quiet)) ||
                 (nan_m && (!m_op[MAN_W-1] || sig_quiet));

  assign same = (a_op == m_op) || ~|(a_op[MSB-1:0] | m_op[MSB-1:0]);
  assign lt   = (a_op[MSB] ^ m_op[MSB]) ? a_op[MSB] :
                a_op[MSB] ? (a_op[MSB-1:0] > m_op[MSB-1:0]) :
                            (a_op[MSB-1:0] < m_op[MSB-1:0]);

  always_comb begin
    if (unord)     flags_c = 4'b0011;
    else if (same) flags_c = 4'b0110;
    else if (lt)   flags_c = 4'b1000;
    else           flags_c = 4'b0010;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          nzcv <= 4'b0000;
          inv  <= 1'b0;
        end else begin
          nzcv <= flags_c;
          inv  <= inv_c;
        end
      end
    end else begin : g_comb
      assign nzcv = flags_c;
      assign inv  = inv_c;
    end
  endgenerate
endmodule

// File: rtl/fcmp_flags_chk.sv
module fcmp_flags_chk #(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter bit REG_OUT = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [EXP_W+MAN_W:0] a_op,
  input logic [EXP_W+MAN_W:0] b_op,
  input logic                 sig_quiet,
  input logic                 cmp_zero,
  input logic [3:0]           nzcv,
  input logic                 inv
);
  localparam int MSB = EXP_W + MAN_W;

  logic [MSB:0] a_s, b_s, m_s;
  logic         sq_s, cz_s, v;

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          a_s <= '0; b_s <= '0; sq_s <= 1'b0; cz_s <= 1'b0; v <= 1'b0;
        end else begin
          a_s <= a_op; b_s <= b_op; sq_s <= sig_quiet; cz_s <= cmp_zero; v <= 1'b1;
        end
      end
    end else begin : g_now
      assign a_s = a_op;
      assign b_s = b_op;
      assign sq_s = sig_quiet;
      assign cz_s = cmp_zero;
      assign v = 1'b1;
    end
  endgenerate

  assign m_s = cz_s ? '0 : b_s;

  logic nan_a, nan_m, zz;
  assign nan_a = (&a_s[MSB-1:MAN_W]) && (|a_s[MAN_W-1:0]);
  assign nan_m = (&m_s[MSB-1:MAN_W]) && (|m_s[MAN_W-1:0]);
  assign zz    = (a_s[MSB-1:0] == '0) && (m_s[MSB-1:0] == '0);

  p_code_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nzcv == 4'b0011) || (nzcv == 4'b0110) || (nzcv == 4'b1000) ||
    (nzcv == 4'b0010) || (nzcv == 4'b0000 && !v));

  p_unordered_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (v && (nan_a || nan_m)) |-> (nzcv == 4'b0011));

  p_no_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (v && !nan_a && !nan_m) |-> !inv);

  p_snan_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (v && nan_a && !a_s[MAN_W-1]) |-> inv);

  p_zeros_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (v && zz) |-> (nzcv == 4'b0110));

  p_sign_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (v && !nan_a && !nan_m && !zz && (a_s[MSB] != m_s[MSB])) |->
      (nzcv == (a_s[MSB] ? 4'b1000 : 4'b0010)));

  p_zero_operand_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (v && cz_s && !nan_a && a_s[MSB-1:0] == '0) |-> (nzcv == 4'b0110 && !inv));
endmodule

bind fcmp_flags fcmp_flags_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_op(a_op), .b_op(b_op), .sig_quiet(sig_quiet),
  .cmp_zero(cmp_zero), .nzcv(nzcv), .inv(inv)
);

// File: tb/fcmp_flags_bench.sv
module fcmp_flags_bench;
  localparam int EW = 3;
  localparam int MW = 2;
  localparam int WD = 1 + EW + MW;
  localparam int NV = 1 << WD;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [WD-1:0] a_op = '0, b_op = '0;
  logic          sig_quiet = 1'b0, cmp_zero = 1'b0;
  logic [3:0]    nzcv;
  logic          inv;
  int            checks = 0, fails = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  fcmp_flags #(.EXP_W(EW), .MAN_W(MW), .REG_OUT(1'b1)) u_fcmp_flags (
    .clk(clk), .rst_n(rst_n), .a_op(a_op), .b_op(b_op), .sig_quiet(sig_quiet),
    .cmp_zero(cmp_zero), .nzcv(nzcv), .inv(inv)
  );

  function automatic bit is_nan(logic [WD-1:0] x);
    return (x[WD-2:MW] == {EW{1'b1}}) && (x[MW-1:0] != 0);
  endfunction

  function automatic int value_of(logic [WD-1:0] x);
    int e, mn, mag;
    e  = int'(x[WD-2:MW]);
    mn = int'(x[MW-1:0]);
    mag = (e == 0) ? mn : (((1 << MW) | mn) << (e - 1));
    return x[WD-1] ? -mag : mag;
  endfunction

  task automatic check(string tag, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h (a=%0h b=%0h sq=%0b cz=%0b)",
               tag, act, exp_v, a_op, b_op, sig_quiet, cmp_zero);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset nzcv", int'(nzcv), 0);
    check("R8 reset inv", int'(inv), 0);
    rst_n = 1'b1;

    // R8: output holds until the capturing edge
    @(negedge clk);
    a_op = 6'b100100; b_op = 6'b000100;
    #1 check("R8 hold before edge", int'(nzcv), 4'b0110);
    @(negedge clk);
    check("R8 after edge", int'(nzcv), 4'b1000);

    for (int cz = 0; cz < 2; cz++)
      for (int sq = 0; sq < 2; sq++)
        for (int ai = 0; ai < NV; ai++)
          for (int bi = 0; bi < NV; bi++) begin
            logic [WD-1:0] a, m;
            int ef, ei;
            string tag;
            a = ai[WD-1:0];
            m = cz ? '0 : bi[WD-1:0];
            ei = ((is_nan(a) && (!a[MW-1] || sq != 0)) ||
                  (is_nan(m) && (!m[MW-1] || sq != 0))) ? 1 : 0;
            if (is_nan(a) || is_nan(m)) begin ef = 4'b0011; tag = "R1 unordered"; end
            else if (value_of(a) == value_of(m)) begin ef = 4'b0110; tag = "R3 equal"; end
            else if (value_of(a) < value_of(m)) begin ef = 4'b1000; tag = "R6 less"; end
            else begin ef = 4'b0010; tag = "R6 greater"; end
            if (cz != 0) tag = {tag, " R7 zero operand"};
            else if (!is_nan(a) && !is_nan(m) && a[WD-1] != m[WD-1]) tag = {tag, " R4 sign"};
            else if (!is_nan(a) && !is_nan(m)) tag = {tag, " R5 magnitude"};
            a_op = a; b_op = bi[WD-1:0];
            sig_quiet = sq[0]; cmp_zero = cz[0];
            @(negedge clk);
            check(tag, int'(nzcv), ef);
            check("R2 invalid", int'(inv), ei);
          end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule